// File: doc/BRIEF.md
# Cipher Coprocessor Transfer Sequencer

This block sits between a byte-wide host register port and a 128-bit block-cipher engine. Software, or a DMA controller acting for it, reaches the block through three byte registers: a control/status register, a data-in register and a data-out register. A start command latches the chaining mode and direction. The block then requests input bytes over one DMA request line and collects them in a staging buffer. When the segment is full it pulses the engine start. On engine completion it captures the result and requests its readout over a second DMA request line.

Block-style modes (ECB, CBC and the MAC-accumulating mode) move a whole 128-bit block per engine run. Stream-style modes (CFB, OFB, CTR) split each 128-bit block into four 32-bit pieces. Each piece has its own input request, engine run and output request, and the next piece is requested automatically. A sticky completion flag is set when the last piece of a block finishes, and it drives the interrupt line when interrupts are enabled. The block never restarts by itself: every block needs a fresh start command. The chaining state lives in the engine, so software may rewrite the mode between blocks. For example, the MAC mode is used for all blocks but the last, and CBC is used for the final block.

Top module: `ciph_dma_seq`

## Requirements
- R1: Register addresses are 0 for control/status, 1 for data-in and 2 for data-out. The control/status bits are: bit 0 start on write and error flag on read; bits 3:1 mode (0 ECB, 1 CBC, 2 CFB, 3 OFB, 4 CTR, 5 MAC); bit 4 encrypt; bit 5 interrupt enable; bit 6 completion flag; bit 7 read-only ready. After reset, address 0 reads 0x80.
- R2: A start command written while ready raises `dma_req_in` in the cycle after the write, and ready reads 0.
- R3: `dma_req_in` is high exactly while segment bytes are awaited, and `dma_req_out` is high exactly while result bytes remain unread. The two are never high together, and both are low after reset.
- R4: In modes 0, 1 and 5, 16 bytes are shifted into `eng_data` most-significant byte first, and `eng_start` pulses for one cycle after the 16th byte. The result is then read back as 16 bytes starting from `eng_result[127:120]`.
- R5: In modes 2, 3 and 4, each piece is 4 bytes shifted into `eng_data[31:0]`, and its result is read from `eng_result[31:0]`, high byte first. There are four pieces per block, with `eng_piece` giving the index 0..3, and `dma_req_in` returns by itself after each piece except the fourth.
- R6: The completion flag is set when the engine finishes the last piece of a block, and `irq` equals flag AND enable. Writing 0 to bit 6 clears the flag and writing 1 leaves it unchanged. A completion in the same cycle as a clearing write leaves the flag set.
- R7: After the last result byte of a block is read, ready returns to 1 and both request lines stay low until the next start. A start written while not ready is ignored.
- R8: `eng_mode` and `eng_encrypt` carry the mode and direction latched at the accepted start. Rewriting the mode field during a block alters neither the segment size nor `eng_mode`, and switching from mode 5 to mode 1 between blocks is accepted.
- R9: A data-in write while result bytes are pending is dropped: the pending output bytes are unchanged and the error flag is set. The next accepted start clears the error flag.
- R10: A data-out read while no result is pending returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops data-out) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| dma_req_in | output | 1 | Request to fill the data-in register |
| dma_req_out | output | 1 | Request to drain the data-out register |
| irq | output | 1 | Completion interrupt request |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_data | output | 128 | Staged input to the engine |
| eng_mode | output | 3 | Latched chaining mode |
| eng_encrypt | output | 1 | Latched direction, 1 = encrypt |
| eng_piece | output | 2 | Piece index within the block |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | 128 | Engine output, valid with eng_done |

## Verification
Two events can land on the completion flag in the same clock: the engine finishing a block, which sets it, and a software write to control/status with bit 6 at 0, which clears it. The bench gives its engine model a one-cycle latency and times a clearing control write to be sampled on the same edge as `eng_done`. It then reads the register and expects the flag still set while the result drains. The bench also forces a data-in write into the drain phase and judges, through the scoreboard, that the remaining output bytes are the ones expected.

// File: rtl/cds_pkg.sv
package cds_pkg;
  localparam int CDS_BYTE_W = 8;
  localparam int CDS_BLK_W  = 128;
  localparam int CDS_SEG_W  = 32;

  localparam logic [2:0] MD_ECB = 3'd0;
  localparam logic [2:0] MD_CBC = 3'd1;
  localparam logic [2:0] MD_CFB = 3'd2;
  localparam logic [2:0] MD_OFB = 3'd3;
  localparam logic [2:0] MD_CTR = 3'd4;
  localparam logic [2:0] MD_MAC = 3'd5;

  // control/status bit positions
  localparam int CB_START = 0;
  localparam int CB_MODE  = 1;
  localparam int CB_ENC   = 4;
  localparam int CB_IE    = 5;
  localparam int CB_DONE  = 6;
  localparam int CB_RDY   = 7;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_DIN  = 2'd1;
  localparam logic [1:0] RA_DOUT = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_DRAIN} cds_state_e;

  function automatic logic mode_is_stream(input logic [2:0] m);
    return (m == MD_CFB) || (m == MD_OFB) || (m == MD_CTR);
  endfunction
endpackage

// File: rtl/cds_stage.sv
module cds_stage #(
  parameter int BYTE_W = 8,
  parameter int BLK_W  = 128,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  output logic [BLK_W-1:0]  data_q,
  output logic [CNT_W-1:0]  cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      cnt_q  <= '0;
    end else if (push) begin
      data_q <= {data_q[BLK_W-BYTE_W-1:0], din};
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cds_drain.sv
module cds_drain #(
  parameter int BYTE_W = 8,
  parameter int BLK_W  = 128,
  parameter int SEG_W  = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              narrow,
  input  logic [CNT_W-1:0]  len,
  input  logic [BLK_W-1:0]  res,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic [CNT_W-1:0]  rem_q
);
  logic [BLK_W-1:0] obuf_q;
  logic [BLK_W-1:0] load_val;

  // a narrow piece sits in the low bits of the result; move it to the top
  assign load_val = narrow ? {res[SEG_W-1:0], {(BLK_W-SEG_W){1'b0}}} : res;
  assign head     = obuf_q[BLK_W-1 -: BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obuf_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      obuf_q <= load_val;
      rem_q  <= len;
    end else if (pop) begin
      obuf_q <= {obuf_q[BLK_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      rem_q  <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/ciph_dma_seq.sv
module ciph_dma_seq
  import cds_pkg::*;
#(
  parameter int BYTE_W = CDS_BYTE_W,
  parameter int BLK_W  = CDS_BLK_W,
  parameter int SEG_W  = CDS_SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              dma_req_in,
  output logic              dma_req_out,
  output logic              irq,
  output logic              eng_start,
  output logic [BLK_W-1:0]  eng_data,
  output logic [2:0]        eng_mode,
  output logic              eng_encrypt,
  output logic [$clog2(BLK_W/SEG_W)-1:0] eng_piece,
  input  logic              eng_done,
  input  logic [BLK_W-1:0]  eng_result
);
  localparam int BLK_BYTES = BLK_W / BYTE_W;
  localparam int SEG_BYTES = SEG_W / BYTE_W;
  localparam int PIECES    = BLK_W / SEG_W;
  localparam int CNT_W     = $clog2(BLK_BYTES) + 1;
  localparam int PC_W      = $clog2(PIECES);

  function automatic logic [CNT_W-1:0] seg_len_f(input logic stream);
    return stream ? CNT_W'(SEG_BYTES) : CNT_W'(BLK_BYTES);
  endfunction

  cds_state_e       st_q;
  logic [2:0]       mode_q, act_mode_q;
  logic             enc_q, act_enc_q, ie_q, done_q, err_q, start_q;
  logic [PC_W-1:0]  piece_q;
  logic [CNT_W-1:0] stg_cnt, rem_cnt, seg_n;
  logic [BYTE_W-1:0] out_head;
  logic             unused_wbit;

  // named internal events
  logic wr_ctrl, wr_din, rd_dout, start_evt, push_evt, bad_wr;
  logic seg_full, pop_evt, drain_last, eng_ok, block_done_evt;
  logic act_stream, last_piece, ready_w;

  assign unused_wbit    = reg_wdata[CB_RDY];
  assign wr_ctrl        = reg_wr && (reg_addr == RA_CTRL);
  assign wr_din         = reg_wr && (reg_addr == RA_DIN);
  assign rd_dout        = reg_rd && (reg_addr == RA_DOUT);
  assign ready_w        = (st_q == ST_IDLE);
  assign start_evt      = wr_ctrl && reg_wdata[CB_START] && ready_w;
  assign push_evt       = wr_din && (st_q == ST_LOAD);
  assign bad_wr         = wr_din && (st_q == ST_DRAIN);
  assign act_stream     = mode_is_stream(act_mode_q);
  assign seg_n          = seg_len_f(act_stream);
  assign seg_full       = push_evt && (stg_cnt == seg_n - 1'b1);
  assign pop_evt        = rd_dout && (st_q == ST_DRAIN);
  assign drain_last     = pop_evt && (rem_cnt == CNT_W'(1));
  assign last_piece     = !act_stream || (piece_q == PC_W'(PIECES - 1));
  assign eng_ok         = (st_q == ST_RUN) && eng_done;
  assign block_done_evt = eng_ok && last_piece;

  cds_stage #(.BYTE_W(BYTE_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) stage_i (
    .clk(clk), .rst_n(rst_n), .clr(start_evt || drain_last), .push(push_evt),
    .din(reg_wdata), .data_q(eng_data), .cnt_q(stg_cnt)
  );

  cds_drain #(.BYTE_W(BYTE_W), .BLK_W(BLK_W), .SEG_W(SEG_W), .CNT_W(CNT_W)) drain_i (
    .clk(clk), .rst_n(rst_n), .load(eng_ok), .narrow(act_stream), .len(seg_n),
    .res(eng_result), .pop(pop_evt), .head(out_head), .rem_q(rem_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      piece_q    <= '0;
      act_mode_q <= MD_ECB;
      act_enc_q  <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      start_q <= seg_full;
      unique case (st_q)
        ST_IDLE: if (start_evt) begin
          st_q       <= ST_LOAD;
          piece_q    <= '0;
          act_mode_q <= reg_wdata[CB_MODE +: 3];
          act_enc_q  <= reg_wdata[CB_ENC];
        end
        ST_LOAD: if (seg_full) st_q <= ST_RUN;
        ST_RUN:  if (eng_done) st_q <= ST_DRAIN;
        ST_DRAIN: if (drain_last) begin
          if (last_piece) st_q <= ST_IDLE;
          else begin
            st_q    <= ST_LOAD;
            piece_q <= piece_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MD_ECB;
      enc_q  <= 1'b0;
      ie_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= reg_wdata[CB_MODE +: 3];
        enc_q  <= reg_wdata[CB_ENC];
        ie_q   <= reg_wdata[CB_IE];
      end
      if (block_done_evt)                      done_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata[CB_DONE]) done_q <= 1'b0;
      if (bad_wr)         err_q <= 1'b1;
      else if (start_evt) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL: reg_rdata = BYTE_W'({ready_w, done_q, ie_q, enc_q, mode_q, err_q});
      RA_DOUT: reg_rdata = (st_q == ST_DRAIN) ? out_head : '0;
      default: reg_rdata = '0;
    endcase
  end

  assign dma_req_in  = (st_q == ST_LOAD);
  assign dma_req_out = (st_q == ST_DRAIN);
  assign irq         = done_q && ie_q;
  assign eng_start   = start_q;
  assign eng_mode    = act_mode_q;
  assign eng_encrypt = act_enc_q;
  assign eng_piece   = piece_q;
endmodule

// File: rtl/cds_checker.sv
module cds_checker (
  input logic clk,
  input logic rst_n,
  input logic dma_req_in,
  input logic dma_req_out,
  input logic eng_start,
  input logic ready,
  input logic start_evt,
  input logic block_done_evt,
  input logic done_q,
  input logic bad_wr,
  input logic err_q
);
  p_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (dma_req_in && !ready));

  p_req_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req_in && dma_req_out));

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    block_done_evt |=> done_q);

  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !start_evt) |=> ready);

  p_bad_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> (err_q && dma_req_out));
endmodule

bind ciph_dma_seq cds_checker chk_i (
  .clk(clk), .rst_n(rst_n), .dma_req_in(dma_req_in), .dma_req_out(dma_req_out),
  .eng_start(eng_start), .ready(ready_w), .start_evt(start_evt),
  .block_done_evt(block_done_evt), .done_q(done_q), .bad_wr(bad_wr), .err_q(err_q)
);

// File: tb/ciph_dma_seq_tb_top.sv
module ciph_dma_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic dma_req_in, dma_req_out, irq, eng_start, eng_encrypt;
  logic [127:0] eng_data;
  logic [2:0] eng_mode;
  logic [1:0] eng_piece;
  logic eng_done = 1'b0;
  logic [127:0] eng_result = '0;

  int n_chk = 0, n_fail = 0;
  int eng_lat = 3;
  int start_cnt = 0;
  logic [2:0] seen_mode = 3'd7;
  logic mon_on = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  ciph_dma_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req_in(dma_req_in),
    .dma_req_out(dma_req_out), .irq(irq), .eng_start(eng_start), .eng_data(eng_data),
    .eng_mode(eng_mode), .eng_encrypt(eng_encrypt), .eng_piece(eng_piece),
    .eng_done(eng_done), .eng_result(eng_result)
  );

  function automatic logic [7:0] msk(input logic enc, input logic [2:0] m);
    return enc ? (8'h5A ^ {5'd0, m}) : 8'hC3;
  endfunction

  // engine model
  initial begin
    forever begin
      logic [127:0] d;
      @(posedge clk iff eng_start);
      seen_mode = eng_mode;
      start_cnt++;
      d = eng_data ^ {16{msk(eng_encrypt, eng_mode)}};
      repeat (eng_lat) @(negedge clk);
      eng_result = d;
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sb_cmp(input logic [7:0] act);
    if (exp_q.size() == 0) chk("R4/R5 unexpected output byte", {24'd0, act}, 32'hFFFF);
    else chk("R4/R5 scoreboard byte", {24'd0, act}, {24'd0, exp_q.pop_front()});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // driver: feeds bytes on request, pushes expected result bytes
  task automatic push_seg(input int n, input logic [7:0] base, input logic enc, input logic [2:0] m);
    for (int i = 0; i < n; i++) begin
      while (!dma_req_in) @(negedge clk);
      exp_q.push_back((base + 8'(i)) ^ msk(enc, m));
      wr(2'd1, base + 8'(i));
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || dma_req_in || dma_req_out) @(negedge clk);
  endtask

  // monitor: drains on request and compares against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && dma_req_out) begin
        logic [7:0] b;
        rd(2'd2, b);
        sb_cmp(b);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    int sc;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R3 reset state
    rd(2'd0, r);                 chk("R1 reset ctrl", {24'd0, r}, 32'h80);
    chk("R3 reset req in", {31'd0, dma_req_in}, 0);
    chk("R3 reset req out", {31'd0, dma_req_out}, 0);
    chk("R6 reset irq", {31'd0, irq}, 0);
    rd(2'd2, r);                 chk("R10 idle data-out", {24'd0, r}, 0);

    // R2 / R4 ECB encrypt, interrupt disabled
    wr(2'd0, 8'h11);
    chk("R2 req in after start", {31'd0, dma_req_in}, 1);
    rd(2'd0, r);                 chk("R2 ready low", {24'd0, r}, 32'h10);
    mon_on = 1'b1;
    push_seg(16, 8'h10, 1'b1, 3'd0);
    wait_idle();
    mon_on = 1'b0;
    rd(2'd0, r);                 chk("R6 done set, ready back", {24'd0, r}, 32'hD0);
    chk("R6 irq gated off", {31'd0, irq}, 0);
    chk("R4 one engine run", start_cnt, 1);
    chk("R8 mode to engine", {29'd0, seen_mode}, 0);

    // R6 clear by writing 0
    wr(2'd0, 8'h30);
    rd(2'd0, r);                 chk("R6 clear flag", {24'd0, r}, 32'hB0);

    // R5 CTR stream, interrupt enabled
    sc = start_cnt;
    wr(2'd0, 8'h39);
    mon_on = 1'b1;
    push_seg(4, 8'h40, 1'b1, 3'd4);
    for (int k = 1; k < 4; k++) begin
      while (!dma_req_in) @(negedge clk);
      chk("R5 piece index", {30'd0, eng_piece}, k);
      chk("R5 no irq mid block", {31'd0, irq}, 0);
      push_seg(4, 8'h40 + 8'(4 * k), 1'b1, 3'd4);
    end
    wait_idle();
    mon_on = 1'b0;
    chk("R5 four engine runs", start_cnt - sc, 4);
    chk("R6 irq raised", {31'd0, irq}, 1);
    rd(2'd0, r);                 chk("R6 stream status", {24'd0, r}, 32'hF8);

    // R6 writing 1 keeps, 0 clears
    wr(2'd0, 8'h78);             chk("R6 write 1 keeps", {31'd0, irq}, 1);
    wr(2'd0, 8'h38);             chk("R6 write 0 clears", {31'd0, irq}, 0);

    // R7 no auto restart
    repeat (10) @(negedge clk);
    chk("R7 no restart in", {31'd0, dma_req_in}, 0);
    chk("R7 no restart out", {31'd0, dma_req_out}, 0);

    // R7 / R8 start while busy ignored, ECB decrypt
    sc = start_cnt;
    wr(2'd0, 8'h21);
    mon_on = 1'b1;
    push_seg(5, 8'h80, 1'b0, 3'd0);
    wr(2'd0, 8'h29);
    push_seg(4, 8'h85, 1'b0, 3'd0);
    chk("R8 segment stays 16", {31'd0, dma_req_in}, 1);
    push_seg(7, 8'h89, 1'b0, 3'd0);
    wait_idle();
    mon_on = 1'b0;
    chk("R7 single run", start_cnt - sc, 1);
    chk("R8 active mode kept", {29'd0, seen_mode}, 0);

    // R9 data-in write during drain
    wr(2'd0, 8'h11);
    push_seg(16, 8'hA0, 1'b1, 3'd0);
    while (!dma_req_out) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      rd(2'd2, r);
      sb_cmp(r);
    end
    wr(2'd1, 8'hEE);
    chk("R9 still draining", {31'd0, dma_req_out}, 1);
    rd(2'd0, r);                 chk("R9 error flag", {24'd0, r}, 32'h51);
    mon_on = 1'b1;
    wait_idle();
    mon_on = 1'b0;
    chk("R9 bytes unchanged", exp_q.size(), 0);

    // R8 / R6 MAC blocks then CBC, with set/clear collision
    wr(2'd0, 8'h1B);
    rd(2'd0, r);                 chk("R9 error cleared by start", {24'd0, r}, 32'h1A);
    eng_lat = 1;
    push_seg(16, 8'hC0, 1'b1, 3'd5);
    @(negedge clk);
    wr(2'd0, 8'h1A);
    rd(2'd0, r);                 chk("R6 set wins over clear", {24'd0, r}, 32'h5A);
    chk("R8 MAC mode to engine", {29'd0, seen_mode}, 5);
    mon_on = 1'b1;
    wait_idle();
    wr(2'd0, 8'h13);
    push_seg(16, 8'hD0, 1'b1, 3'd1);
    wait_idle();
    mon_on = 1'b0;
    eng_lat = 3;
    chk("R8 CBC final block", {29'd0, seen_mode}, 1);
    rd(2'd0, r);                 chk("R7 ready after final", {24'd0, r}, 32'hD2);
    rd(2'd2, r);                 chk("R10 data-out empty", {24'd0, r}, 0);
    chk("R3 idle reqs", {30'd0, dma_req_in, dma_req_out}, 0);

    finish_run();
  end
endmodule